// File: doc/BRIEF.md
# Rank-Aware Memory Request Selector

This block chooses the next request to issue from one memory controller's request buffer. The buffer lives inside the block. Each slot is filled through a write port with a thread number, a bank and a row. The block stamps the slot with a free-running cycle count at the moment it is written. Every cycle a reduction tree compares all occupied slots and records the winner in a result register, which drives the grant outputs. When the consumer accepts the grant, the block frees the slot and records the row of the issued request as the open row of its bank.

The winner is chosen by four rules, tested in this order:
1. Anti-starvation: a request that has waited longer than a runtime threshold wins.
2. Thread rank: the request from the thread with the higher rank wins.
3. Row hit: the request that targets the open row of its bank wins.
4. Age: the older request wins.

The ranking of threads is computed outside the block. It arrives as a packed vector and is loaded in full on a single strobe.

Top module: `rank_req_selector`

## Requirements
- R1: After reset no slot is occupied, `grantValid` is 0, no bank has an open row and the cycle count is 0.
- R2: When `wrEn` is high at a clock edge, slot `wrIdx` takes `wrThread`, `wrBank`, `wrRow` and the current cycle count as its arrival stamp. The slot can appear on the grant outputs from the second edge on.
- R3: The age of a slot is the cycle count minus its stamp, taken modulo 2^TS_W. A slot whose age exceeds `starveThresh` beats every slot whose age does not.
- R4: Among slots that exceed the threshold, the oldest wins, whatever their rank or row-hit state.
- R5: Among slots within the threshold, the higher rank wins. The rank of thread t is field `rankVec[t*RANK_W +: RANK_W]`, and a larger value means higher priority.
- R6: Among slots within the threshold that have equal rank, a slot whose row equals the open row of its bank wins.
- R7: When the earlier rules do not decide, the older slot wins. When ages are also equal, the lower slot index wins.
- R8: When `grantAccept` is high while `grantValid` is high, the granted slot is freed and its row becomes the open row of its bank. `grantValid` is then 0 for one cycle.
- R9: `grantValid` is 0 whenever the previous cycle held no occupied slot.
- R10: `rankLoad` captures the whole of `rankVec` at one edge. The grant registered at that same edge still uses the old ranking, and every later grant uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write a slot |
| wrIdx | input | IDX_W | Slot to write |
| wrThread | input | THREAD_W | Thread of the new request |
| wrBank | input | BANK_W | Bank of the new request |
| wrRow | input | ROW_W | Row of the new request |
| starveThresh | input | TS_W | Age limit above which a request is starving |
| rankLoad | input | 1 | Load the rank vector |
| rankVec | input | NUM_THREADS*RANK_W | Per-thread rank fields |
| grantAccept | input | 1 | Consumer takes the current grant |
| grantValid | output | 1 | A winner is offered |
| grantIdx | output | IDX_W | Slot of the winner |
| grantThread | output | THREAD_W | Thread of the winner |
| grantBank | output | BANK_W | Bank of the winner |
| grantRow | output | ROW_W | Row of the winner |

## Verification
Two events can fall in the same cycle: an issue, which frees a slot and moves the open row of its bank, and a selection, which reads that open row and the occupied set. The bench accepts a grant and reads the output in the very next cycle, where a one-cycle gap is expected. It then reads the following selection and checks that it sees the freed slot as gone and the updated open row. A pair of requests to the same bank, where the later one hits only after the first has issued, settles whether the row-hit rule saw the new open row. A rank load that coincides with a selection edge is provoked the same way. The result must switch exactly one cycle later.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef struct packed {
    logic issue;     // current grant accepted this cycle
    logic rankLoad;  // capture the rank vector at this edge
  } ctrlStrobe_t;
endpackage

// File: rtl/rs_control.sv
module rs_control
  import rs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        winAny,
  input  logic        grantAccept,
  input  logic        rankLoad,
  output logic        grantValid,
  output ctrlStrobe_t strobe
);
  logic bubbleQ;

  // The registered winner is stale for one cycle after an issue
  assign grantValid      = winAny && !bubbleQ;
  assign strobe.issue    = grantAccept && grantValid;
  assign strobe.rankLoad = rankLoad;

  always_ff @(posedge clk) begin
    if (!rstN) bubbleQ <= 1'b0;
    else       bubbleQ <= strobe.issue;
  end
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int NUM_ENTRIES = 128,
  parameter int NUM_BANKS   = 4,
  parameter int NUM_THREADS = 4,
  parameter int RANK_W      = 2,
  parameter int ROW_W       = 14,
  parameter int TS_W        = 32,
  localparam int IDX_W    = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int THREAD_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [IDX_W-1:0]              wrIdx,
  input  logic [THREAD_W-1:0]           wrThread,
  input  logic [BANK_W-1:0]             wrBank,
  input  logic [ROW_W-1:0]              wrRow,
  input  logic [TS_W-1:0]               starveThresh,
  input  logic [NUM_THREADS*RANK_W-1:0] rankVec,
  input  ctrlStrobe_t                   strobe,
  output logic                          winAny,
  output logic [IDX_W-1:0]              winIdx,
  output logic [THREAD_W-1:0]           winThread,
  output logic [BANK_W-1:0]             winBank,
  output logic [ROW_W-1:0]              winRow,
  output logic [NUM_ENTRIES-1:0]        validVec,
  output logic [NUM_BANKS*ROW_W-1:0]    openRowFlat
);
  localparam int LEAVES = 1 << IDX_W;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int KEY_W  = 3 + RANK_W + TS_W;

  logic [THREAD_W-1:0] entThread [NUM_ENTRIES];
  logic [BANK_W-1:0]   entBank   [NUM_ENTRIES];
  logic [ROW_W-1:0]    entRow    [NUM_ENTRIES];
  logic [TS_W-1:0]     entTs     [NUM_ENTRIES];
  logic [ROW_W-1:0]    openRow   [NUM_BANKS];
  logic [NUM_BANKS-1:0] openVld;
  logic [RANK_W-1:0]   rankQ     [NUM_THREADS];
  logic [TS_W-1:0]     nowQ;
  logic [IDX_W-1:0]    winIdxQ;
  logic                winAnyQ;

  logic [KEY_W-1:0] nodeKey [NODES];
  logic [IDX_W-1:0] nodeIdx [NODES];

  // Slot occupancy: write wins over a same-cycle free of the same slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobe.issue && winIdxQ == IDX_W'(i)) validVec[i] <= 1'b0;
        if (wrEn && wrIdx == IDX_W'(i))            validVec[i] <= 1'b1;
      end
    end
  end

  // Payload carries no reset; it is qualified by validVec
  always_ff @(posedge clk) begin
    if (wrEn) begin
      entThread[wrIdx] <= wrThread;
      entBank[wrIdx]   <= wrBank;
      entRow[wrIdx]    <= wrRow;
      entTs[wrIdx]     <= nowQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowQ    <= '0;
      openVld <= '0;
      winIdxQ <= '0;
      winAnyQ <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) openRow[b] <= '0;
      for (int t = 0; t < NUM_THREADS; t++) rankQ[t] <= '0;
    end else begin
      nowQ    <= nowQ + 1'b1;
      winIdxQ <= nodeIdx[0];
      winAnyQ <= nodeKey[0][KEY_W-1];
      if (strobe.issue) begin
        openRow[entBank[winIdxQ]] <= entRow[winIdxQ];
        openVld[entBank[winIdxQ]] <= 1'b1;
      end
      if (strobe.rankLoad)
        for (int t = 0; t < NUM_THREADS; t++) rankQ[t] <= rankVec[t*RANK_W +: RANK_W];
    end
  end

  // Leaf keys: {valid, starved, rank, hit, age}; larger key wins
  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_ENTRIES) begin : g_real
      logic [TS_W-1:0]   age;
      logic              starved;
      logic              hit;
      logic [RANK_W-1:0] rk;
      assign age     = nowQ - entTs[i];
      assign starved = age > starveThresh;
      assign rk      = rankQ[entThread[i]];
      assign hit     = openVld[entBank[i]] && (openRow[entBank[i]] == entRow[i]);
      assign nodeKey[LEAVES-1+i] = !validVec[i] ? '0 :
          starved ? {2'b11, {RANK_W{1'b0}}, 1'b0, age} : {2'b10, rk, hit, age};
      assign nodeIdx[LEAVES-1+i] = IDX_W'(i);
    end else begin : g_pad
      assign nodeKey[LEAVES-1+i] = '0;
      assign nodeIdx[LEAVES-1+i] = '0;
    end
  end

  // Heap-ordered tree; on equal keys the left (lower index) side wins
  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic pickLeft;
    assign pickLeft   = nodeKey[2*n+1] >= nodeKey[2*n+2];
    assign nodeKey[n] = pickLeft ? nodeKey[2*n+1] : nodeKey[2*n+2];
    assign nodeIdx[n] = pickLeft ? nodeIdx[2*n+1] : nodeIdx[2*n+2];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_open
    assign openRowFlat[b*ROW_W +: ROW_W] = openRow[b];
  end

  assign winAny    = winAnyQ;
  assign winIdx    = winIdxQ;
  assign winThread = entThread[winIdxQ];
  assign winBank   = entBank[winIdxQ];
  assign winRow    = entRow[winIdxQ];
endmodule

// File: rtl/rank_req_selector.sv
module rank_req_selector
  import rs_pkg::*;
#(
  parameter int NUM_ENTRIES = 128,
  parameter int NUM_BANKS   = 4,
  parameter int NUM_THREADS = 4,
  parameter int RANK_W      = 2,
  parameter int ROW_W       = 14,
  parameter int TS_W        = 32,
  localparam int IDX_W    = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int THREAD_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [IDX_W-1:0]              wrIdx,
  input  logic [THREAD_W-1:0]           wrThread,
  input  logic [BANK_W-1:0]             wrBank,
  input  logic [ROW_W-1:0]              wrRow,
  input  logic [TS_W-1:0]               starveThresh,
  input  logic                          rankLoad,
  input  logic [NUM_THREADS*RANK_W-1:0] rankVec,
  input  logic                          grantAccept,
  output logic                          grantValid,
  output logic [IDX_W-1:0]              grantIdx,
  output logic [THREAD_W-1:0]           grantThread,
  output logic [BANK_W-1:0]             grantBank,
  output logic [ROW_W-1:0]              grantRow
);
  ctrlStrobe_t                strobe;
  logic                       winAny;
  logic [NUM_ENTRIES-1:0]     validVec;
  logic [NUM_BANKS*ROW_W-1:0] openRowFlat;

  rs_control u_ctrl (
    .clk(clk), .rstN(rstN), .winAny(winAny), .grantAccept(grantAccept),
    .rankLoad(rankLoad), .grantValid(grantValid), .strobe(strobe)
  );

  rs_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_BANKS(NUM_BANKS), .NUM_THREADS(NUM_THREADS),
    .RANK_W(RANK_W), .ROW_W(ROW_W), .TS_W(TS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrThread(wrThread),
    .wrBank(wrBank), .wrRow(wrRow), .starveThresh(starveThresh), .rankVec(rankVec),
    .strobe(strobe), .winAny(winAny), .winIdx(grantIdx), .winThread(grantThread),
    .winBank(grantBank), .winRow(grantRow), .validVec(validVec), .openRowFlat(openRowFlat)
  );
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int NUM_ENTRIES = 128,
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 14,
  localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
  input logic                       clk,
  input logic                       rstN,
  input logic                       grantValid,
  input logic                       grantAccept,
  input logic [IDX_W-1:0]           grantIdx,
  input logic [BANK_W-1:0]          grantBank,
  input logic [ROW_W-1:0]           grantRow,
  input logic [NUM_ENTRIES-1:0]     validVec,
  input logic [NUM_BANKS*ROW_W-1:0] openRowFlat
);
  // R8
  bubble_after_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantAccept && grantValid) |=> !grantValid);

  // R8
  slot_freed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantAccept && grantValid) |=> !validVec[$past(grantIdx)]);

  // R8
  open_row_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantAccept && grantValid) |=>
      openRowFlat[$past(grantBank)*ROW_W +: ROW_W] == $past(grantRow));

  // R2
  grant_occupied_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> validVec[grantIdx]);

  // R9
  empty_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validVec == '0) |=> !grantValid);
endmodule

bind rank_req_selector rs_checker #(
  .NUM_ENTRIES(NUM_ENTRIES), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rstN(rstN), .grantValid(grantValid), .grantAccept(grantAccept),
  .grantIdx(grantIdx), .grantBank(grantBank), .grantRow(grantRow),
  .validVec(validVec), .openRowFlat(openRowFlat)
);

// File: tb/rank_req_selector_bench.sv
module rank_req_selector_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  wrIdx = '0;
  logic [1:0]  wrThread = '0;
  logic [1:0]  wrBank = '0;
  logic [13:0] wrRow = '0;
  logic [31:0] starveThresh = 32'd1000;
  logic        rankLoad = 1'b0;
  logic [7:0]  rankVec = '0;
  logic        grantAccept = 1'b0;
  logic        grantValid;
  logic [6:0]  grantIdx;
  logic [1:0]  grantThread;
  logic [1:0]  grantBank;
  logic [13:0] grantRow;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_req_selector u_rank_req_selector (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrThread(wrThread),
    .wrBank(wrBank), .wrRow(wrRow), .starveThresh(starveThresh), .rankLoad(rankLoad),
    .rankVec(rankVec), .grantAccept(grantAccept), .grantValid(grantValid),
    .grantIdx(grantIdx), .grantThread(grantThread), .grantBank(grantBank),
    .grantRow(grantRow)
  );

  typedef struct packed {
    logic [6:0]  idxA;
    logic [1:0]  thrA;
    logic [1:0]  bankA;
    logic [13:0] rowA;
    logic [6:0]  idxB;
    logic [1:0]  thrB;
    logic [1:0]  bankB;
    logic [13:0] rowB;
    logic [6:0]  first;
    logic [6:0]  second;
  } vec_t;

  // A is written one cycle before B; rank of thread t is t.
  // Open rows at each step follow from the issues of the vectors before it.
  localparam vec_t VECS [5] = '{
    '{7'd3,   2'd1, 2'd0, 14'd5, 7'd10, 2'd2, 2'd1, 14'd7, 7'd10,  7'd3},   // R5 rank
    '{7'd20,  2'd1, 2'd0, 14'd9, 7'd21, 2'd1, 2'd0, 14'd5, 7'd21,  7'd20},  // R6 hit
    '{7'd40,  2'd0, 2'd2, 14'd1, 7'd41, 2'd0, 2'd3, 14'd2, 7'd40,  7'd41},  // R7 age
    '{7'd100, 2'd2, 2'd1, 14'd3, 7'd5,  2'd0, 2'd1, 14'd7, 7'd100, 7'd5},   // R5 rank over hit
    '{7'd127, 2'd3, 2'd0, 14'd9, 7'd0,  2'd3, 2'd0, 14'd9, 7'd127, 7'd0}    // R7 age over index
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(input logic [6:0] idx, input logic [1:0] thr,
                       input logic [1:0] bank, input logic [13:0] row);
    wrEn = 1'b1; wrIdx = idx; wrThread = thr; wrBank = bank; wrRow = row;
    tick();
    wrEn = 1'b0;
  endtask

  // Accept the current grant, then check the one-cycle gap (R8)
  task automatic take(input string req);
    grantAccept = 1'b1;
    tick();
    grantAccept = 1'b0;
    check({req, " R8 gap after issue"}, int'(grantValid), 0);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    check("R1 no grant in reset", int'(grantValid), 0);
    rstN = 1'b1;
    tick();
    tick();
    check("R1 no grant after reset", int'(grantValid), 0);
    rankVec = {2'd3, 2'd2, 2'd1, 2'd0};
    rankLoad = 1'b1;
    tick();
    rankLoad = 1'b0;

    for (int v = 0; v < 5; v++) begin
      write(VECS[v].idxA, VECS[v].thrA, VECS[v].bankA, VECS[v].rowA);
      write(VECS[v].idxB, VECS[v].thrB, VECS[v].bankB, VECS[v].rowB);
      tick();
      check("R2 valid after writes", int'(grantValid), 1);
      check("R5/R6/R7 first winner", int'(grantIdx), int'(VECS[v].first));
      take("table");
      check("R7 second winner", int'(grantIdx), int'(VECS[v].second));
      take("table");
      check("R9 drained", int'(grantValid), 0);
    end

    // R3: an old request beats a fresh high-rank row hit
    starveThresh = 32'd5;
    write(7'd50, 2'd0, 2'd2, 14'd8);
    repeat (10) tick();
    write(7'd51, 2'd3, 2'd2, 14'd1);
    tick();
    check("R3 starving wins", int'(grantIdx), 50);
    check("R2 payload row", int'(grantRow), 8);
    take("R3");
    check("R3 remaining", int'(grantIdx), 51);
    take("R3");

    // R4: both starving, oldest wins despite lower rank and no hit
    write(7'd60, 2'd0, 2'd3, 14'd6);
    repeat (2) tick();
    write(7'd61, 2'd3, 2'd3, 14'd2);
    repeat (20) tick();
    check("R4 oldest starving wins", int'(grantIdx), 60);
    check("R2 payload thread", int'(grantThread), 0);
    take("R4");
    check("R4 remaining", int'(grantIdx), 61);
    take("R4");
    check("R9 drained", int'(grantValid), 0);

    // R10: rank reload switches the winner one cycle after the load edge
    starveThresh = 32'd1000;
    write(7'd70, 2'd0, 2'd0, 14'd3);
    write(7'd71, 2'd3, 2'd1, 14'd4);
    tick();
    check("R5 higher rank wins", int'(grantIdx), 71);
    rankVec = {2'd0, 2'd1, 2'd2, 2'd3};
    rankLoad = 1'b1;
    tick();
    rankLoad = 1'b0;
    check("R10 old rank at load edge", int'(grantIdx), 71);
    tick();
    check("R10 new rank applies", int'(grantIdx), 70);
    check("R2 payload bank", int'(grantBank), 0);
    take("R10");
    check("R10 remaining", int'(grantIdx), 71);
    take("R10");
    check("R9 drained", int'(grantValid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule